// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block searches for the reference divider M, feedback divider N and post-divider P of a pixel clock PLL. The caller presents a requested pixel frequency, the PLL reference frequency, the permitted VCO window and a mode-dependent ceiling on the pixel clock, all as unsigned integers in kHz. It then pulses `start`. The engine latches the operands and limits the request to a legal range. It then steps through every post-divider and reference-divider pair, one candidate at a time. For each pair that passes the range checks it works out a rounded feedback divider with a serial divider. It keeps the candidate whose output frequency lies closest to the request.

The error comparison is exact. Each candidate's error is kept as a fraction, and two candidates are compared by cross-multiplication, so no rounding can change which candidate wins. When the search ends, the engine raises `done` for one cycle and presents the packed control word. If no pair passed every check, it raises a flag instead.

Top module: `pll_divider_search`

## Requirements
- R1: The effective request is first raised to floor(vco_min_khz / 16) when it is lower than that value.
- R2: The raised request is then lowered to pclk_max_khz when it exceeds it. The ceiling wins over the floor.
- R3: Post-dividers are tried in the order 1, 2, 4, 8, 16. A post-divider is skipped when request × P is below vco_min_khz or above vco_max_khz.
- R4: For each post-divider, reference dividers M = 7 to 14 are tried in increasing order. M is skipped unless 1000·M ≤ fref_khz ≤ 2000·M.
- R5: N = floor((2·vco·M + fref) / (2·fref)), which is vco·M/fref rounded half up. A candidate is rejected when N is 0 or above 255.
- R6: The candidate error is |req·M·P − fref·N| / (M·P). The best candidate is replaced only by a strictly smaller error, so the earliest one tried wins a tie.
- R7: The result word is {P code in bits 23:16, N in bits 15:8, M in bits 7:0}. The P code is log2(P), giving 0 to 4.
- R8: When no candidate survives, no_solution is 1 and pll_word is 0. Otherwise no_solution is 0.
- R9: A start pulse in idle is accepted. busy is 1 from the next cycle until the result cycle. done is a one-cycle pulse, with busy low, in the cycle the result appears. A start pulse while busy is ignored.
- R10: After reset, busy, done, no_solution and pll_word are all 0. The results hold their value until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search, accepted only when idle |
| req_khz | input | FW | Requested pixel frequency |
| fref_khz | input | FW | PLL reference frequency |
| vco_min_khz | input | FW | Lowest permitted VCO frequency |
| vco_max_khz | input | FW | Highest permitted VCO frequency |
| pclk_max_khz | input | FW | Ceiling on the pixel frequency for the current mode |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| no_solution | output | 1 | No candidate passed the checks |
| pll_word | output | 24 | Packed {P code, N, M} |

## Verification
Fixed cases use typical references. One reference admits only M = 14, which separates the phase check from the divider loop. Requests below the floor and above the ceiling are each run a second time at their clamped value, and the two results must match at the ports. Two cases have no solution, one through a reference that no M can satisfy and one through a VCO window that no P can reach, so the flag is tested on both of its causes. Randomised operands then exercise ties and rounding edges against an integer reference model. A start pulse sent in mid-search shows that a busy engine ignores new operands.

// File: rtl/pll_search_pkg.sv
// Shared constants and state type for the divider search engine.
package pll_search_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCREEN,
        ST_DIV,
        ST_FINISH
    } srch_state_e;

    localparam int M_FIRST_DEF  = 7;
    localparam int M_LAST_DEF   = 14;
    localparam int P_STEPS_DEF  = 5;
    localparam int PH_LO_DEF    = 1000;
    localparam int PH_HI_DEF    = 2000;
endpackage

// File: rtl/pll_req_clamp.sv
// Request limiter: raises the request to vco_min/16, then lowers it to the
// mode ceiling. Purely combinational; assumes unsigned kHz operands.
module pll_req_clamp #(
    parameter int FW = 20
) (
    input  logic [FW-1:0] req,
    input  logic [FW-1:0] vco_min,
    input  logic [FW-1:0] pclk_max,
    output logic [FW-1:0] eff
);
    logic [FW-1:0] floor_v;
    logic [FW-1:0] raised;

    // Apply floor first, ceiling second so that the ceiling dominates.
    always_comb begin
        floor_v = vco_min >> 4;
        raised  = (req < floor_v) ? floor_v : req;
        eff     = (raised > pclk_max) ? pclk_max : raised;
    end
endmodule

// File: rtl/pll_ndiv.sv
// Serial restoring divider producing a QW-bit quotient, one bit per cycle.
// Assumes divisor is nonzero whenever go is pulsed; ovf flags a quotient
// that does not fit in QW bits. done pulses one cycle after the last step.
module pll_ndiv #(
    parameter int WW = 31,
    parameter int QW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [WW-1:0] dividend,
    input  logic [WW-1:0] divisor,
    output logic          done,
    output logic          ovf,
    output logic [QW-1:0] quot
);
    localparam int BW = $clog2(QW);

    logic [WW-1:0] rem_q;
    logic [WW-1:0] dsr_q;
    logic [BW-1:0] bit_q;
    logic          run_q;
    logic [WW-1:0] trial;

    // Shifted divisor for the quotient bit under test.
    always_comb trial = dsr_q << bit_q;

    // Load on go, then subtract-and-shift from the top quotient bit down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            dsr_q <= '0;
            bit_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
            ovf   <= 1'b0;
            quot  <= '0;
        end else if (go) begin
            rem_q <= dividend;
            dsr_q <= divisor;
            bit_q <= BW'(QW-1);
            run_q <= 1'b1;
            done  <= 1'b0;
            ovf   <= (dividend >= (divisor << QW));
            quot  <= '0;
        end else if (run_q) begin
            if (rem_q >= trial) begin
                rem_q       <= rem_q - trial;
                quot[bit_q] <= 1'b1;
            end
            if (bit_q == '0) begin
                run_q <= 1'b0;
                done  <= 1'b1;
            end else begin
                bit_q <= bit_q - 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/pll_err_cmp.sv
// Candidate error as the fraction |req*D - fref*N| / D with D = M*P, and an
// exact cross-multiplied comparison against the best one so far.
module pll_err_cmp #(
    parameter int FW = 20,
    parameter int MW = 8,
    parameter int NW = 8
) (
    input  logic [FW-1:0]   req,
    input  logic [FW-1:0]   fref,
    input  logic [MW-1:0]   m,
    input  logic [2:0]      p_sh,
    input  logic [NW-1:0]   n,
    input  logic            have_best,
    input  logic [FW+7:0]   best_e,
    input  logic [MW-1:0]   best_d,
    output logic [FW+7:0]   cand_e,
    output logic [MW-1:0]   cand_d,
    output logic            better
);
    localparam int EW = FW + 8;
    localparam int XW = EW + MW;

    logic [EW-1:0] lhs;
    logic [EW-1:0] rhs;

    // Error numerator, denominator and strict-improvement test.
    always_comb begin
        cand_d = m << p_sh;
        lhs    = EW'(req) * EW'(cand_d);
        rhs    = EW'(fref) * EW'(n);
        cand_e = (lhs > rhs) ? (lhs - rhs) : (rhs - lhs);
        better = !have_best ||
                 ((XW'(cand_e) * XW'(best_d)) < (XW'(best_e) * XW'(cand_d)));
    end
endmodule

// File: rtl/pll_divider_search.sv
// Top of the divider search engine. Latches operands on start, screens one
// (P, M) pair per cycle, runs the serial divider on pairs that pass, keeps
// the strictly best candidate and reports the packed word with a done pulse.
// Assumes kHz operands below 2**FW and a reference clock that is not zero
// when a solution is expected.
module pll_divider_search
    import pll_search_pkg::*;
#(
    parameter int FW      = 20,
    parameter int M_FIRST = M_FIRST_DEF,
    parameter int M_LAST  = M_LAST_DEF,
    parameter int P_STEPS = P_STEPS_DEF,
    parameter int PH_LO   = PH_LO_DEF,
    parameter int PH_HI   = PH_HI_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] req_khz,
    input  logic [FW-1:0] fref_khz,
    input  logic [FW-1:0] vco_min_khz,
    input  logic [FW-1:0] vco_max_khz,
    input  logic [FW-1:0] pclk_max_khz,
    output logic          busy,
    output logic          done,
    output logic          no_solution,
    output logic [23:0]   pll_word
);
    localparam int MW = 8;
    localparam int NW = 8;
    localparam int QW = NW + 1;
    localparam int VW = FW + 4;
    localparam int EW = FW + 8;
    localparam int WW = FW + 11;

    srch_state_e   st_q;
    logic [FW-1:0] req_q, fref_q, vmin_q, vmax_q;
    logic [FW-1:0] eff_req;
    logic [2:0]    p_idx_q;
    logic [MW-1:0] m_q;
    logic          have_best_q;
    logic [EW-1:0] best_e_q;
    logic [MW-1:0] best_d_q;
    logic [MW-1:0] best_m_q;
    logic [NW-1:0] best_n_q;
    logic [2:0]    best_p_q;
    logic          done_q, nosol_q;
    logic [23:0]   word_q;

    logic [VW-1:0] vco_c;
    logic          vco_ok, phase_ok, div_go;
    logic [EW-1:0] ph_lo_lim, ph_hi_lim;
    logic [WW-1:0] dividend, divisor;
    logic          div_done, div_ovf;
    logic [QW-1:0] div_q;
    logic          n_ok;
    logic [EW-1:0] cand_e;
    logic [MW-1:0] cand_d;
    logic          better;
    logic          last_m, last_p;

    pll_req_clamp #(.FW(FW)) u_clamp (
        .req      (req_khz),
        .vco_min  (vco_min_khz),
        .pclk_max (pclk_max_khz),
        .eff      (eff_req)
    );

    // Screening of the current (P, M) pair and divider operands.
    always_comb begin
        vco_c     = VW'(req_q) << p_idx_q;
        vco_ok    = (vco_c >= VW'(vmin_q)) && (vco_c <= VW'(vmax_q));
        ph_lo_lim = EW'(m_q) * EW'(PH_LO);
        ph_hi_lim = EW'(m_q) * EW'(PH_HI);
        phase_ok  = (EW'(fref_q) >= ph_lo_lim) && (EW'(fref_q) <= ph_hi_lim);
        dividend  = ((WW'(vco_c) * WW'(m_q)) << 1) + WW'(fref_q);
        divisor   = WW'(fref_q) << 1;
        div_go    = (st_q == ST_SCREEN) && vco_ok && phase_ok;
        n_ok      = !div_ovf && !div_q[QW-1] && (div_q != '0);
        last_m    = (m_q == MW'(M_LAST));
        last_p    = (p_idx_q == 3'(P_STEPS-1));
    end

    pll_ndiv #(.WW(WW), .QW(QW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (divisor),
        .done     (div_done),
        .ovf      (div_ovf),
        .quot     (div_q)
    );

    pll_err_cmp #(.FW(FW), .MW(MW), .NW(NW)) u_cmp (
        .req       (req_q),
        .fref      (fref_q),
        .m         (m_q),
        .p_sh      (p_idx_q),
        .n         (div_q[NW-1:0]),
        .have_best (have_best_q),
        .best_e    (best_e_q),
        .best_d    (best_d_q),
        .cand_e    (cand_e),
        .cand_d    (cand_d),
        .better    (better)
    );

    // Search sequencer: operand capture, candidate walk, best tracking, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            req_q       <= '0;
            fref_q      <= '0;
            vmin_q      <= '0;
            vmax_q      <= '0;
            p_idx_q     <= '0;
            m_q         <= MW'(M_FIRST);
            have_best_q <= 1'b0;
            best_e_q    <= '0;
            best_d_q    <= '0;
            best_m_q    <= '0;
            best_n_q    <= '0;
            best_p_q    <= '0;
            done_q      <= 1'b0;
            nosol_q     <= 1'b0;
            word_q      <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        req_q       <= eff_req;
                        fref_q      <= fref_khz;
                        vmin_q      <= vco_min_khz;
                        vmax_q      <= vco_max_khz;
                        p_idx_q     <= '0;
                        m_q         <= MW'(M_FIRST);
                        have_best_q <= 1'b0;
                        st_q        <= ST_SCREEN;
                    end
                end
                ST_SCREEN: begin
                    if (div_go) begin
                        st_q <= ST_DIV;
                    end else if (last_m) begin
                        m_q     <= MW'(M_FIRST);
                        p_idx_q <= p_idx_q + 3'd1;
                        st_q    <= last_p ? ST_FINISH : ST_SCREEN;
                    end else begin
                        m_q <= m_q + 1'b1;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        if (n_ok && better) begin
                            have_best_q <= 1'b1;
                            best_e_q    <= cand_e;
                            best_d_q    <= cand_d;
                            best_m_q    <= m_q;
                            best_n_q    <= div_q[NW-1:0];
                            best_p_q    <= p_idx_q;
                        end
                        if (last_m) begin
                            m_q     <= MW'(M_FIRST);
                            p_idx_q <= p_idx_q + 3'd1;
                            st_q    <= last_p ? ST_FINISH : ST_SCREEN;
                        end else begin
                            m_q  <= m_q + 1'b1;
                            st_q <= ST_SCREEN;
                        end
                    end
                end
                ST_FINISH: begin
                    word_q  <= have_best_q ? {8'(best_p_q), best_n_q, best_m_q} : 24'd0;
                    nosol_q <= !have_best_q;
                    done_q  <= 1'b1;
                    st_q    <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        busy        = (st_q != ST_IDLE);
        done        = done_q;
        no_solution = nosol_q;
        pll_word    = word_q;
    end
endmodule

// File: rtl/pll_search_chk.sv
// Port-level protocol and result-shape checks for pll_divider_search.
module pll_search_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        no_solution,
    input logic [23:0] pll_word
);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(pll_word) && $stable(no_solution)));
    // R8
    nosol_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_solution |-> (pll_word == 24'd0));
    // R7
    field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |-> ((pll_word[7:0] >= 8'd7) && (pll_word[7:0] <= 8'd14)
                                    && (pll_word[15:8] != 8'd0) && (pll_word[23:16] <= 8'd4)));
endmodule

bind pll_divider_search pll_search_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .no_solution (no_solution),
    .pll_word    (pll_word)
);

// File: tb/sim_pll_divider_search.sv
module sim_pll_divider_search;
    localparam int FW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] req_khz = '0, fref_khz = '0, vco_min_khz = '0, vco_max_khz = '0, pclk_max_khz = '0;
    logic          busy, done, no_solution;
    logic [23:0]   pll_word;

    int compared = 0;
    int mismatched = 0;
    logic [23:0] held_word = '0;
    logic        held_ns = 1'b0;
    bit          mon_on = 1'b0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    pll_divider_search #(.FW(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_khz(req_khz), .fref_khz(fref_khz), .vco_min_khz(vco_min_khz),
        .vco_max_khz(vco_max_khz), .pclk_max_khz(pclk_max_khz),
        .busy(busy), .done(done), .no_solution(no_solution), .pll_word(pll_word)
    );

    // Reference model of R1..R8 with plain integers.
    function automatic void ref_search(input longint req, input longint fref, input longint vmin,
                                       input longint vmax, input longint pmax,
                                       output logic [23:0] w, output logic ns);
        longint r, vco, n, e, d, be, bd;
        bit found;
        r = req;
        if (r < vmin / 16) r = vmin / 16;      // R1
        if (r > pmax) r = pmax;                // R2
        found = 0; be = 0; bd = 1; w = '0;
        for (int k = 0; k < 5; k++) begin      // R3
            vco = r << k;
            if (vco < vmin || vco > vmax) continue;
            for (int m = 7; m <= 14; m++) begin  // R4
                if (fref < 1000 * m || fref > 2000 * m) continue;
                n = (2 * vco * m + fref) / (2 * fref);  // R5
                if (n < 1 || n > 255) continue;
                d = m * (1 << k);
                e = r * d - fref * n;
                if (e < 0) e = -e;
                if (!found || e * bd < be * d) begin  // R6
                    found = 1; be = e; bd = d;
                    w = {8'(k), 8'(n), 8'(m)};        // R7
                end
            end
        end
        ns = !found;                            // R8
    endfunction

    task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
        end
    endtask

    // Per-clock comparison of held results against the model (R10).
    always @(posedge clk) begin
        #1;
        if (mon_on && !done) begin
            check("R10 hold", {7'd0, no_solution, pll_word}, {7'd0, held_ns, held_word});
            if (done !== 1'b0) check("R9 done", {31'd0, done}, 32'd0);
        end
    end

    // Launch one search, optionally poke start mid-run, compare the result.
    task automatic run_case(input string tag, input int r, input int f, input int vmn,
                            input int vmx, input int pm, input bit poke,
                            output logic [23:0] got_w, output logic got_ns);
        logic [23:0] ew;
        logic ens;
        int cyc;
        ref_search(r, f, vmn, vmx, pm, ew, ens);
        @(negedge clk);
        req_khz = FW'(r); fref_khz = FW'(f); vco_min_khz = FW'(vmn);
        vco_max_khz = FW'(vmx); pclk_max_khz = FW'(pm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R9 busy after start ", tag}, {31'd0, busy}, 32'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            req_khz = FW'(r / 2 + 1); fref_khz = 14318; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (done !== 1'b1 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check({"R9 done arrives ", tag}, {31'd0, done}, 32'd1);
        check({"R9 busy low at done ", tag}, {31'd0, busy}, 32'd0);
        check({"R3-R8 word ", tag}, {8'd0, pll_word}, {8'd0, ew});
        check({"R8 flag ", tag}, {31'd0, no_solution}, {31'd0, ens});
        got_w = pll_word; got_ns = no_solution;
        held_word = pll_word; held_ns = no_solution;
        @(negedge clk);
        check({"R9 no restart ", tag}, {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [23:0] w1, w2;
        logic n1, n2;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 reset busy", {31'd0, busy}, 32'd0);
        check("R10 reset done", {31'd0, done}, 32'd0);
        check("R10 reset word", {7'd0, no_solution, pll_word}, 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R6 R7 typical search
        run_case("typ", 65000, 13500, 128000, 350000, 350000, 0, w1, n1);
        check("R7 typ solution", {31'd0, n1}, 32'd0);
        // R1 floor: 1000 must behave like 128000/16 = 8000
        run_case("low", 1000, 13500, 128000, 350000, 350000, 0, w1, n1);
        run_case("low8k", 8000, 13500, 128000, 350000, 350000, 0, w2, n2);
        check("R1 floor equivalence", {7'd0, n1, w1}, {7'd0, n2, w2});
        // R2 ceiling wins
        run_case("high", 500000, 13500, 128000, 350000, 135000, 0, w1, n1);
        run_case("high135", 135000, 13500, 128000, 350000, 135000, 0, w2, n2);
        check("R2 ceiling equivalence", {7'd0, n1, w1}, {7'd0, n2, w2});
        // R4 only M=14 admissible with 27 MHz
        run_case("m14", 40000, 27000, 128000, 350000, 350000, 0, w1, n1);
        check("R4 only M14", {24'd0, w1[7:0]}, 32'd14);
        // R8 no M passes the phase window
        run_case("nophase", 65000, 50000, 128000, 350000, 350000, 0, w1, n1);
        check("R8 phase nosol", {31'd0, n1}, 32'd1);
        // R3 R8 no P reaches the VCO window
        run_case("novco", 30000, 13500, 400000, 410000, 350000, 0, w1, n1);
        check("R3 vco nosol", {31'd0, n1}, 32'd1);
        // R5 rounding with an awkward reference
        run_case("r5", 25175, 14318, 128000, 350000, 350000, 0, w1, n1);
        // R9 start during busy is ignored
        run_case("poke", 108000, 13500, 128000, 350000, 350000, 1, w1, n1);
        // R6 randomised operands
        for (int i = 0; i < 30; i++) begin
            int f, r, vmn, vmx, pm;
            f   = 7000 + int'($urandom_range(0, 21000));
            r   = 5000 + int'($urandom_range(0, 395000));
            vmn = 100000 + int'($urandom_range(0, 100000));
            vmx = vmn + 100000 + int'($urandom_range(0, 200000));
            pm  = 100000 + int'($urandom_range(0, 300000));
            run_case("rand", r, f, vmn, vmx, pm, 0, w1, n1);
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule